// File: doc/BRIEF.md
# Interrupt distributor register block

This block is the state-holding half of an interrupt distributor. It keeps, for each of a fixed number of interrupt sources, an enable flag, a pending flag, an 8-bit priority, an 8-bit CPU target mask, a model bit and a trigger-mode bit. Software reaches this state through byte-wide writes into a 4 KiB register window, and can read it back through the same address. The enable and pending banks are written with write-one-to-set and write-one-to-clear bytes that each cover eight sources. The configuration bank packs two bits per source, so one byte covers four sources.

The block also watches one input line per source. Level-triggered sources latch pending while they are high and enabled. Edge-triggered sources latch pending on a rising edge. A write to a reserved or out-of-range location raises an error flag for one cycle and changes no state. Priority arbitration toward the CPUs, acknowledge and completion handling, and word-wide access are left to the neighbouring logic, which reads `pending_o`, `enable_o` and the stored bytes.

Top module: `idist_regs`

## Requirements
- R1: After reset the global enable is 0 and every pending flag is 0. Sources 0 to 15 are enabled and edge-triggered, which reads as 0xAA at 0xC00. All other sources are disabled and level-triggered. Model bits and priorities are 0. Every target byte is 1 when NUM_CPU is 1, and 0 otherwise.
- R2: A write to offset 0x000 sets the global enable to data bit 0, and offset 0x000 reads back {7'b0, enable}. Writes to offsets 0x001 to 0x003 are accepted, raise no error and change nothing.
- R3: A write to offset 0x100+k sets the enable of source 8k+j for each 1 in data bit j, and 0 bits change nothing. Offsets 0x100+k and 0x180+k both read back the enable byte of sources 8k to 8k+7, with source 8k+j in bit j.
- R4: A write to offset 0x180+k clears the enable of source 8k+j for each 1 in data bit j.
- R5: Offsets 0x200+k and 0x280+k set and clear the pending flags with the same write-one packing as the enable banks. Both offsets read back the pending byte. A pending flag falls only through a clear-pending write.
- R6: Offsets 0x400+n and 0x800+n hold the priority byte and the target byte of source n. Each is written and read back as a whole byte.
- R7: Offset 0xC00+k holds the configuration of sources 4k to 4k+3. Source 4k+j uses data bit 2j as its model bit and bit 2j+1 as its trigger bit, where 1 means edge and 0 means level. The byte reads back in the same layout.
- R8: A source that is level-triggered and enabled, and whose input is high at a clock edge, is pending after that edge. The flag stays latched after the input falls, until a clear-pending write. A disabled level source does not become pending.
- R9: When a set-enable write enables a level-triggered source whose input is high, that source is pending after the same clock edge as the write.
- R10: An edge-triggered source becomes pending after the clock edge at which its input is sampled high, having been sampled low at the previous edge. This happens whether or not the source is enabled. An input that stays high does not set the flag again.
- R11: When a set event (a rising edge, a high enabled level source, or a set-enable rule) falls in the same cycle as a clear-pending write for that source, the source is pending afterwards.
- R12: A write is illegal in four cases: to offsets 0x004 to 0x0FF, to offsets 0x300 to 0x3FF, to offsets 0xF00 and above, or to any location whose first covered source index is NUM_IRQ or more. An illegal write makes `wr_err_o` 1 for exactly the next cycle and changes no state. A legal write leaves `wr_err_o` at 0.
- R13: A write takes effect at the clock edge that samples `wr_en_i`. `rd_data_o` is combinational from `addr_i` and the current state, so before that edge it still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 12 | Byte offset within the window, used for both write and read |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Read data for `addr_i` |
| irq_level_i | input | NUM_IRQ | Input line of each source |
| dist_en_o | output | 1 | Global distributor enable |
| enable_o | output | NUM_IRQ | Per-source enable flags |
| pending_o | output | NUM_IRQ | Per-source pending flags |
| wr_err_o | output | 1 | One-cycle flag for an illegal write in the previous cycle |

## Verification
A clear-pending write can land in the same cycle as a hardware set event for the same source. The set event is either a rising edge on an edge-triggered line or a held-high input on an enabled level source. The bench provokes the edge case by raising the input on the same falling edge where it presents the clear write. It provokes the level case by issuing the clear while the input stays high. It then expects the flag to read 1 after the edge, as R11 requires. The set-enable rule of R9 is also separated from the plain level rule: one cycle after enabling a source whose line is already high, the bench looks for pending, a cycle earlier than the level rule alone could produce it.

// File: rtl/idist_pkg.sv
package idist_pkg;

  localparam int ADDR_W = 12;
  localparam int BASE_W = 13;

  typedef enum logic [3:0] {
    RG_CTRL,
    RG_IGN,
    RG_SETEN,
    RG_CLREN,
    RG_SETPD,
    RG_CLRPD,
    RG_PRIO,
    RG_TGT,
    RG_CFG,
    RG_BAD
  } region_e;

  typedef struct packed {
    region_e           rg;
    logic [BASE_W-1:0] base;
    logic              legal;
  } dec_t;

  // Classify a byte offset into a register region
  function automatic region_e region_of(input logic [ADDR_W-1:0] a);
    region_e r;
    if (a == 12'h000)      r = RG_CTRL;
    else if (a < 12'h004)  r = RG_IGN;
    else if (a < 12'h100)  r = RG_BAD;
    else if (a < 12'h180)  r = RG_SETEN;
    else if (a < 12'h200)  r = RG_CLREN;
    else if (a < 12'h280)  r = RG_SETPD;
    else if (a < 12'h300)  r = RG_CLRPD;
    else if (a < 12'h400)  r = RG_BAD;
    else if (a < 12'h800)  r = RG_PRIO;
    else if (a < 12'hC00)  r = RG_TGT;
    else if (a < 12'hF00)  r = RG_CFG;
    else                   r = RG_BAD;
    return r;
  endfunction

  // First source index covered by the byte at offset a
  function automatic logic [BASE_W-1:0] first_src(input region_e r,
                                                  input logic [ADDR_W-1:0] a);
    logic [BASE_W-1:0] x;
    x = {1'b0, a};
    case (r)
      RG_SETEN: return (x - 13'h100) << 3;
      RG_CLREN: return (x - 13'h180) << 3;
      RG_SETPD: return (x - 13'h200) << 3;
      RG_CLRPD: return (x - 13'h280) << 3;
      RG_PRIO:  return x - 13'h400;
      RG_TGT:   return x - 13'h800;
      RG_CFG:   return (x - 13'hC00) << 2;
      default:  return '0;
    endcase
  endfunction

  function automatic logic is_legal(input region_e r,
                                    input logic [BASE_W-1:0] b,
                                    input int num_irq);
    if (r == RG_BAD) return 1'b0;
    if (r == RG_CTRL || r == RG_IGN) return 1'b1;
    return (int'(b) < num_irq);
  endfunction

endpackage

// File: rtl/idist_decode.sv
module idist_decode
  import idist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  region_e           rg;
  logic [BASE_W-1:0] base;

  always_comb begin
    rg          = region_of(addr_i);
    base        = first_src(rg, addr_i);
    dec_o.rg    = rg;
    dec_o.base  = base;
    dec_o.legal = is_legal(rg, base, NUM_IRQ);
  end

endmodule

// File: rtl/idist_src.sv
module idist_src
  import idist_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int NUM_CPU = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok_i,
  input  dec_t       dec_i,
  input  logic [7:0] wr_byte_i,
  input  logic       level_i,
  output logic       enable_o,
  output logic       pending_o,
  output logic       model_o,
  output logic       trig_o,
  output logic [7:0] prio_o,
  output logic [7:0] tgt_o,
  output logic       seten_lvl_o,
  output logic       clren_o,
  output logic       edge_o,
  output logic       clrpd_o
);

  localparam logic [BASE_W-1:0] BANK_BASE = BASE_W'((IDX / 8) * 8);
  localparam int                BANK_BIT  = IDX % 8;
  localparam logic [BASE_W-1:0] CFG_BASE  = BASE_W'((IDX / 4) * 4);
  localparam int                CFG_SH    = 2 * (IDX % 4);
  localparam logic [BASE_W-1:0] OWN_IDX   = BASE_W'(IDX);
  localparam logic              RST_ON    = (IDX < 16);
  localparam logic [7:0]        RST_TGT   = (NUM_CPU == 1) ? 8'd1 : 8'd0;

  logic in_bank, bank_bit, in_cfg, in_own;
  logic seten, clren, setpd, clrpd, prio_wr, tgt_wr, cfg_wr;
  logic level_q, rise, edge_set, lvl_set, seten_lvl;
  logic en_q, pd_q, mdl_q, trg_q;
  logic [7:0] prio_q, tgt_q;

  assign in_bank  = (dec_i.base == BANK_BASE);
  assign bank_bit = wr_byte_i[BANK_BIT];
  assign in_cfg   = (dec_i.base == CFG_BASE);
  assign in_own   = (dec_i.base == OWN_IDX);

  assign seten   = wr_ok_i && dec_i.rg == RG_SETEN && in_bank && bank_bit;
  assign clren   = wr_ok_i && dec_i.rg == RG_CLREN && in_bank && bank_bit;
  assign setpd   = wr_ok_i && dec_i.rg == RG_SETPD && in_bank && bank_bit;
  assign clrpd   = wr_ok_i && dec_i.rg == RG_CLRPD && in_bank && bank_bit;
  assign prio_wr = wr_ok_i && dec_i.rg == RG_PRIO && in_own;
  assign tgt_wr  = wr_ok_i && dec_i.rg == RG_TGT && in_own;
  assign cfg_wr  = wr_ok_i && dec_i.rg == RG_CFG && in_cfg;

  assign rise      = level_i && !level_q;
  assign edge_set  = trg_q && rise;
  assign lvl_set   = !trg_q && level_i && en_q;
  assign seten_lvl = seten && level_i && !trg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      en_q    <= RST_ON;
      trg_q   <= RST_ON;
      mdl_q   <= 1'b0;
      pd_q    <= 1'b0;
      prio_q  <= 8'd0;
      tgt_q   <= RST_TGT;
    end else begin
      level_q <= level_i;
      if (seten)      en_q <= 1'b1;
      else if (clren) en_q <= 1'b0;
      // set events win over a clear-pending write in the same cycle
      pd_q <= (pd_q && !clrpd) || setpd || edge_set || lvl_set || seten_lvl;
      if (prio_wr) prio_q <= wr_byte_i;
      if (tgt_wr)  tgt_q  <= wr_byte_i;
      if (cfg_wr) begin
        mdl_q <= wr_byte_i[CFG_SH];
        trg_q <= wr_byte_i[CFG_SH+1];
      end
    end
  end

  assign enable_o    = en_q;
  assign pending_o   = pd_q;
  assign model_o     = mdl_q;
  assign trig_o      = trg_q;
  assign prio_o      = prio_q;
  assign tgt_o       = tgt_q;
  assign seten_lvl_o = seten_lvl;
  assign clren_o     = clren;
  assign edge_o      = edge_set;
  assign clrpd_o     = clrpd;

endmodule

// File: rtl/idist_rdmux.sv
module idist_rdmux
  import idist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  dec_t                      dec_i,
  input  logic                      dist_en_i,
  input  logic [NUM_IRQ-1:0]        en_v_i,
  input  logic [NUM_IRQ-1:0]        pd_v_i,
  input  logic [NUM_IRQ-1:0]        mdl_v_i,
  input  logic [NUM_IRQ-1:0]        trg_v_i,
  input  logic [NUM_IRQ-1:0][7:0]   prio_v_i,
  input  logic [NUM_IRQ-1:0][7:0]   tgt_v_i,
  output logic [7:0]                rd_o
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  function automatic logic in_range(input logic [BASE_W-1:0] ix);
    return int'(ix) < NUM_IRQ;
  endfunction

  always_comb begin
    logic [BASE_W-1:0] ix;
    rd_o = 8'd0;
    ix   = dec_i.base;
    case (dec_i.rg)
      RG_CTRL: rd_o = {7'd0, dist_en_i};
      RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD: begin
        for (int j = 0; j < 8; j++) begin
          ix = dec_i.base + BASE_W'(j);
          if (in_range(ix)) begin
            if (dec_i.rg == RG_SETEN || dec_i.rg == RG_CLREN)
              rd_o[j] = en_v_i[ix[IDX_W-1:0]];
            else
              rd_o[j] = pd_v_i[ix[IDX_W-1:0]];
          end
        end
      end
      RG_PRIO: if (in_range(ix)) rd_o = prio_v_i[ix[IDX_W-1:0]];
      RG_TGT:  if (in_range(ix)) rd_o = tgt_v_i[ix[IDX_W-1:0]];
      RG_CFG: begin
        for (int j = 0; j < 4; j++) begin
          ix = dec_i.base + BASE_W'(j);
          if (in_range(ix)) begin
            rd_o[2*j]   = mdl_v_i[ix[IDX_W-1:0]];
            rd_o[2*j+1] = trg_v_i[ix[IDX_W-1:0]];
          end
        end
      end
      default: rd_o = 8'd0;
    endcase
  end

endmodule

// File: rtl/idist_regs.sv
module idist_regs
  import idist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [11:0]        addr_i,
  input  logic [7:0]         wr_data_i,
  output logic [7:0]         rd_data_o,
  input  logic [NUM_IRQ-1:0] irq_level_i,
  output logic               dist_en_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic               wr_err_o
);

  dec_t dec;
  logic wr_ok;
  logic illegal_wr;
  logic dist_en_q, err_q;

  logic [NUM_IRQ-1:0]      mdl_v, trg_v;
  logic [NUM_IRQ-1:0][7:0] prio_v, tgt_v;

  // named internal events for the checker
  logic [NUM_IRQ-1:0] seten_lvl_hit, clren_hit, edge_hit, clrpd_hit;

  idist_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  assign wr_ok      = wr_en_i && dec.legal;
  assign illegal_wr = wr_en_i && !dec.legal;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    idist_src #(.IDX(i), .NUM_CPU(NUM_CPU)) u_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ok_i     (wr_ok),
      .dec_i       (dec),
      .wr_byte_i   (wr_data_i),
      .level_i     (irq_level_i[i]),
      .enable_o    (enable_o[i]),
      .pending_o   (pending_o[i]),
      .model_o     (mdl_v[i]),
      .trig_o      (trg_v[i]),
      .prio_o      (prio_v[i]),
      .tgt_o       (tgt_v[i]),
      .seten_lvl_o (seten_lvl_hit[i]),
      .clren_o     (clren_hit[i]),
      .edge_o      (edge_hit[i]),
      .clrpd_o     (clrpd_hit[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_en_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= illegal_wr;
      if (wr_ok && dec.rg == RG_CTRL) dist_en_q <= wr_data_i[0];
    end
  end

  idist_rdmux #(.NUM_IRQ(NUM_IRQ)) u_rd (
    .dec_i     (dec),
    .dist_en_i (dist_en_q),
    .en_v_i    (enable_o),
    .pd_v_i    (pending_o),
    .mdl_v_i   (mdl_v),
    .trg_v_i   (trg_v),
    .prio_v_i  (prio_v),
    .tgt_v_i   (tgt_v),
    .rd_o      (rd_data_o)
  );

  assign dist_en_o = dist_en_q;
  assign wr_err_o  = err_q;

endmodule

// File: rtl/idist_chk.sv
module idist_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               illegal_wr,
  input logic               wr_err_o,
  input logic               dist_en_o,
  input logic [NUM_IRQ-1:0] enable_o,
  input logic [NUM_IRQ-1:0] pending_o,
  input logic [NUM_IRQ-1:0] seten_lvl_hit,
  input logic [NUM_IRQ-1:0] clren_hit,
  input logic [NUM_IRQ-1:0] edge_hit,
  input logic [NUM_IRQ-1:0] clrpd_hit
);

  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> wr_err_o); // R12

  AST_LEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_wr |=> !wr_err_o); // R12

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> ($stable(enable_o) && $stable(dist_en_o))); // R12

  AST_SETEN_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|seten_lvl_hit) |=> ((pending_o & $past(seten_lvl_hit)) == $past(seten_lvl_hit))); // R9

  AST_CLREN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clren_hit) |=> ((enable_o & $past(clren_hit)) == '0)); // R4

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((pending_o & $past(edge_hit)) == $past(edge_hit))); // R10

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pending_o) & ~pending_o) & ~$past(clrpd_hit)) == '0)); // R5

endmodule

bind idist_regs idist_chk #(.NUM_IRQ(NUM_IRQ)) u_idist_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .illegal_wr    (illegal_wr),
  .wr_err_o      (wr_err_o),
  .dist_en_o     (dist_en_o),
  .enable_o      (enable_o),
  .pending_o     (pending_o),
  .seten_lvl_hit (seten_lvl_hit),
  .clren_hit     (clren_hit),
  .edge_hit      (edge_hit),
  .clrpd_hit     (clrpd_hit)
);

// File: tb/idist_regs_bench.sv
`timescale 1ns/1ps
module idist_regs_bench;

  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [11:0]  addr_i = '0;
  logic [7:0]   wr_data_i = '0;
  logic [7:0]   rd_data_o;
  logic [N-1:0] irq_level_i = '0;
  logic         dist_en_o;
  logic [N-1:0] enable_o;
  logic [N-1:0] pending_o;
  logic         wr_err_o;

  always #4 clk = ~clk;

  idist_regs #(.NUM_IRQ(N), .NUM_CPU(1)) u_idist_regs (
    .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en_i), .addr_i (addr_i),
    .wr_data_i (wr_data_i), .rd_data_o (rd_data_o), .irq_level_i (irq_level_i),
    .dist_en_o (dist_en_o), .enable_o (enable_o), .pending_o (pending_o),
    .wr_err_o (wr_err_o)
  );

  // scoreboard item kinds
  localparam int K_RD = 0, K_ERR = 1, K_PB = 2, K_DEN = 3;

  typedef struct {
    int          kind;
    int          idx;
    logic [7:0]  exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    nvec = 0;
  int    nbad = 0;
  bit    done = 1'b0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [7:0] got;
      wait (q.size() > 0);
      it = q.pop_front();
      case (it.kind)
        K_RD:    got = rd_data_o;
        K_ERR:   got = {7'd0, wr_err_o};
        K_PB:    got = {7'd0, pending_o[it.idx]};
        default: got = {7'd0, dist_en_o};
      endcase
      nvec++;
      if (got !== it.exp) begin
        nbad++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, got, it.exp);
      end
    end
  end

  task automatic push(input int kind, input int idx, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = e; it.tag = tag;
    q.push_back(it);
    #0.1;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [7:0] e, input string tag);
    addr_i = a;
    #0.1;
    push(K_RD, 0, e, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 reset state
    push(K_DEN, 0, 8'h00, "R1 dist_en");
    push(K_PB, 0, 8'h00, "R1 pending0");
    chk_rd(12'h100, 8'hFF, "R1 en 0-7");
    chk_rd(12'h101, 8'hFF, "R1 en 8-15");
    idle();
    chk_rd(12'h102, 8'h00, "R1 en 16-23");
    chk_rd(12'hC00, 8'hAA, "R1 cfg 0-3");
    chk_rd(12'hC04, 8'h00, "R1 cfg 16-19");
    idle();
    chk_rd(12'h800, 8'h01, "R1 target0");
    chk_rd(12'h83F, 8'h01, "R1 target63");
    chk_rd(12'h400, 8'h00, "R1 prio0");

    // R2 control byte and ignored offsets
    wr(12'h000, 8'h01);
    push(K_ERR, 0, 8'h00, "R2 legal no err");
    push(K_DEN, 0, 8'h01, "R2 dist_en set");
    chk_rd(12'h000, 8'h01, "R2 readback");
    wr(12'h002, 8'hFE);
    push(K_ERR, 0, 8'h00, "R2 ignored no err");
    push(K_DEN, 0, 8'h01, "R2 ignored keeps");

    // R3 set enable
    wr(12'h102, 8'h05);
    chk_rd(12'h102, 8'h05, "R3 set bits");
    wr(12'h102, 8'h00);
    chk_rd(12'h182, 8'h05, "R3 zero bits no effect");

    // R4 clear enable
    wr(12'h182, 8'h01);
    chk_rd(12'h102, 8'h04, "R4 clear irq16");
    wr(12'h180, 8'hF0);
    chk_rd(12'h100, 8'h0F, "R4 clear 4-7");

    // R5 set / clear pending
    wr(12'h207, 8'h81);
    push(K_PB, 56, 8'h01, "R5 pend56");
    push(K_PB, 57, 8'h00, "R5 pend57");
    chk_rd(12'h287, 8'h81, "R5 readback");
    wr(12'h287, 8'h01);
    chk_rd(12'h207, 8'h80, "R5 clear56");
    wr(12'h287, 8'h80);
    chk_rd(12'h207, 8'h00, "R5 clear63");

    // R6 priority and target
    wr(12'h405, 8'h3C);
    chk_rd(12'h405, 8'h3C, "R6 prio5");
    chk_rd(12'h404, 8'h00, "R6 prio4 untouched");
    wr(12'h805, 8'h02);
    chk_rd(12'h805, 8'h02, "R6 target5");

    // R7 configuration: irq16 edge, irq17 model=1 level
    wr(12'hC04, 8'h06);
    chk_rd(12'hC04, 8'h06, "R7 cfg readback");

    // R8 level source: enable irq20, raise its line
    wr(12'h102, 8'h10);
    push(K_PB, 20, 8'h00, "R8 low line not pending");
    irq_level_i[20] = 1'b1;
    idle();
    push(K_PB, 20, 8'h01, "R8 level pends");
    irq_level_i[20] = 1'b0;
    idle();
    push(K_PB, 20, 8'h01, "R8 latched after fall");
    wr(12'h282, 8'h10);
    push(K_PB, 20, 8'h00, "R8 cleared");
    irq_level_i[21] = 1'b1;
    idle();
    idle();
    push(K_PB, 21, 8'h00, "R8 disabled level ignored");

    // R9 enabling a high level source pends it with the write
    wr(12'h102, 8'h20);
    push(K_PB, 21, 8'h01, "R9 set-enable pends");
    wr(12'h182, 8'h20);
    wr(12'h282, 8'h20);
    push(K_PB, 21, 8'h00, "R9 disabled then cleared");
    irq_level_i[21] = 1'b0;

    // R10 edge source irq16 (disabled)
    idle();
    irq_level_i[16] = 1'b1;
    idle();
    push(K_PB, 16, 8'h01, "R10 edge pends while disabled");
    wr(12'h282, 8'h01);
    push(K_PB, 16, 8'h00, "R10 cleared");
    idle();
    push(K_PB, 16, 8'h00, "R10 held line no re-arm");
    irq_level_i[16] = 1'b0;
    idle();

    // R11 rising edge coincides with clear-pending write
    wr(12'h202, 8'h01);
    push(K_PB, 16, 8'h01, "R11 pre-set");
    @(negedge clk);
    irq_level_i[16] = 1'b1;
    addr_i = 12'h282; wr_data_i = 8'h01; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    push(K_PB, 16, 8'h01, "R11 edge beats clear");
    // R11 level source held high beats clear
    irq_level_i[20] = 1'b1;
    idle();
    wr(12'h282, 8'h10);
    push(K_PB, 20, 8'h01, "R11 level beats clear");
    irq_level_i[20] = 1'b0;
    idle();
    wr(12'h282, 8'h10);
    push(K_PB, 20, 8'h00, "R11 clear after fall");

    // R12 illegal writes
    wr(12'h004, 8'h00);
    push(K_ERR, 0, 8'h01, "R12 err 0x004");
    push(K_DEN, 0, 8'h01, "R12 0x004 no change");
    idle();
    push(K_ERR, 0, 8'h00, "R12 err one cycle");
    wr(12'h108, 8'hFF);
    push(K_ERR, 0, 8'h01, "R12 err bank index");
    chk_rd(12'h107, 8'h00, "R12 bank unchanged");
    wr(12'h300, 8'hFF);
    push(K_ERR, 0, 8'h01, "R12 err active range");
    push(K_PB, 16, 8'h01, "R12 pending kept");
    wr(12'h440, 8'h55);
    push(K_ERR, 0, 8'h01, "R12 err prio index");
    chk_rd(12'h43F, 8'h00, "R12 prio unchanged");
    wr(12'hF00, 8'hFF);
    push(K_ERR, 0, 8'h01, "R12 err high offset");
    wr(12'hC10, 8'hFF);
    push(K_ERR, 0, 8'h01, "R12 err cfg index");
    chk_rd(12'hC0F, 8'h00, "R12 cfg unchanged");

    // R13 write effective at the sampling edge
    @(negedge clk);
    addr_i = 12'h406; wr_data_i = 8'h11; wr_en_i = 1'b1;
    #0.1;
    push(K_RD, 0, 8'h00, "R13 old value before edge");
    @(negedge clk);
    wr_en_i = 1'b0;
    chk_rd(12'h406, 8'h11, "R13 new value after edge");

    idle();
    wait (q.size() == 0);
    #0.1;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule